// File: doc/BRIEF.md
# Sticky Event Status and Interrupt Mask Register

This block is one byte of host-visible interrupt state for a stream decoder's buffer monitor. Four single-cycle event pulses report an overflow or an underflow (buffer empty) of either the audio or the video elementary-stream buffer. Each pulse sets its own sticky status bit. The bit then stays set until the host collects it.

The host sees a single address with two meanings. A read presents the status byte and clears every status bit at the clock edge that ends the read. A write does not touch status. It loads per-bit masks at the same positions, and those masks gate only the active-low interrupt pin. A masked event is still recorded in status, so the host can poll it. The interrupt pin stays low while any recorded event has its mask clear.

The host strobes are plain control pins. They carry no handshake and never stall: a read or a write is taken in the cycle where its strobe is high. Read data is a combinational view of the status flops, so it is valid in the same cycle as the read strobe.

Top module: `irq_status_reg`

## Requirements
- R1: During and after reset, until an event occurs, host_rdata is 0x00 and irq_n is 1. All masks reset to 0, which means every interrupt is enabled.
- R2: An event pulse sampled at a clock edge sets its status bit from that edge onward. The bit positions are fixed: evt_aud_ovf sets bit 0, evt_vid_ovf sets bit 1, evt_aud_udf sets bit 4 and evt_vid_udf sets bit 5.
- R3: A set status bit stays set through any number of cycles without a read. A further pulse on an already-set bit leaves it set.
- R4: In a cycle where host_rd is 1, host_rdata shows the status value from before the clear. At that cycle's clock edge every status bit is cleared, except as given in R5.
- R5: An event that arrives in the same cycle as a read leaves its status bit set after the clear.
- R6: A write (host_wr = 1) loads host_wdata bits 0, 1, 4 and 5 as the mask bits for the events at those positions. A write never changes any status bit.
- R7: irq_n is 0 exactly when at least one status bit is set while its mask bit is 0. irq_n follows the registered state in the same cycle, with no extra delay.
- R8: An event whose mask bit is 1 still sets its status bit, but it does not pull irq_n low.
- R9: Bits 2, 3, 6 and 7 of host_rdata always read 0. Writing to those bit positions has no effect on status or on irq_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| host_rd | input | 1 | Host read strobe; status is cleared at the end of the cycle |
| host_wr | input | 1 | Host write strobe; loads the masks |
| host_wdata | input | 8 | Mask byte written by the host |
| host_rdata | output | 8 | Current status byte |
| evt_aud_ovf | input | 1 | Audio buffer overflow pulse |
| evt_vid_ovf | input | 1 | Video buffer overflow pulse |
| evt_aud_udf | input | 1 | Audio buffer underflow pulse |
| evt_vid_udf | input | 1 | Video buffer underflow pulse |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
An event, a read clear or a mask write each takes effect at the first rising edge that samples it. The new value shows on host_rdata and irq_n right after that edge. The pre-clear read value, by contrast, is already present in the cycle the read strobe is high. The bench drives inputs on the falling edge. It then checks host_rdata against the model's pre-edge status while the strobe is still up. After the next rising edge it advances its model, and it compares both outputs again on the following falling edge. This way every result is taken exactly one edge after its cause.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int REG_W = 8;
  localparam int BIT_AUD_OVF = 0;
  localparam int BIT_VID_OVF = 1;
  localparam int BIT_AUD_UDF = 4;
  localparam int BIT_VID_UDF = 5;
  localparam logic [REG_W-1:0] EVT_BITS = (REG_W'(1) << BIT_AUD_OVF) |
                                          (REG_W'(1) << BIT_VID_OVF) |
                                          (REG_W'(1) << BIT_AUD_UDF) |
                                          (REG_W'(1) << BIT_VID_UDF);
endpackage

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set wins over clear so a colliding event is never dropped
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int                W    = 8,
  parameter logic [W-1:0]      KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] mask_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (KEEP[i]) begin : g_ff
      always_ff @(posedge clk) begin
        if (!rst_n)      mask_o[i] <= 1'b0;
        else if (load_i) mask_o[i] <= data_i[i];
      end
    end else begin : g_tie
      assign mask_o[i] = 1'b0;
    end
  end

  logic unused_rsvd;
  assign unused_rsvd = ^(data_i & ~KEEP);
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int W = 8
) (
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_n_o
);
  logic [W-1:0] live;
  assign live    = status_i & ~mask_i;
  assign irq_n_o = ~(|live);
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic             evt_aud_ovf,
  input  logic             evt_vid_ovf,
  input  logic             evt_aud_udf,
  input  logic             evt_vid_udf,
  output logic             irq_n
);
  logic [REG_W-1:0] evt_vec;
  logic [REG_W-1:0] status;
  logic [REG_W-1:0] mask;

  always_comb begin
    evt_vec              = '0;
    evt_vec[BIT_AUD_OVF] = evt_aud_ovf;
    evt_vec[BIT_VID_OVF] = evt_vid_ovf;
    evt_vec[BIT_AUD_UDF] = evt_aud_udf;
    evt_vec[BIT_VID_UDF] = evt_vid_udf;
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_stat
    if (EVT_BITS[i]) begin : g_live
      irq_sticky_bit u_bit (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_vec[i]),
        .clr_i (host_rd),
        .q_o   (status[i])
      );
    end else begin : g_rsvd
      assign status[i] = 1'b0;
    end
  end

  logic unused_evt;
  assign unused_evt = ^(evt_vec & ~EVT_BITS);

  irq_mask_reg #(.W(REG_W), .KEEP(EVT_BITS)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (host_wr),
    .data_i (host_wdata),
    .mask_o (mask)
  );

  irq_combine #(.W(REG_W)) u_comb (
    .status_i (status),
    .mask_i   (mask),
    .irq_n_o  (irq_n)
  );

  assign host_rdata = status;
endmodule

// File: rtl/irq_status_reg_chk.sv
module irq_status_reg_chk
  import irq_stat_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             host_rd,
  input logic [REG_W-1:0] host_rdata,
  input logic             evt_aud_ovf,
  input logic             evt_vid_ovf,
  input logic             evt_aud_udf,
  input logic             evt_vid_udf,
  input logic             irq_n
);
  logic [REG_W-1:0] evt_any;
  always_comb begin
    evt_any              = '0;
    evt_any[BIT_AUD_OVF] = evt_aud_ovf;
    evt_any[BIT_VID_OVF] = evt_vid_ovf;
    evt_any[BIT_AUD_UDF] = evt_aud_udf;
    evt_any[BIT_VID_UDF] = evt_vid_udf;
  end

  a_r2_aud_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_aud_ovf |=> host_rdata[BIT_AUD_OVF]);
  a_r2_vid_udf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vid_udf |=> host_rdata[BIT_VID_UDF]);
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> ((host_rdata & $past(host_rdata)) == $past(host_rdata)));
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && evt_any == '0) |=> (host_rdata == '0));
  a_r5_collide_kept: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> ((host_rdata & ~$past(evt_any)) == '0 &&
                 (host_rdata & $past(evt_any)) == $past(evt_any)));
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata == '0) |-> irq_n);
  a_r7_low_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (host_rdata != '0));
  a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata & ~EVT_BITS) == '0);
endmodule

bind irq_status_reg irq_status_reg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_rd     (host_rd),
  .host_rdata  (host_rdata),
  .evt_aud_ovf (evt_aud_ovf),
  .evt_vid_ovf (evt_vid_ovf),
  .evt_aud_udf (evt_aud_udf),
  .evt_vid_udf (evt_vid_udf),
  .irq_n       (irq_n)
);

// File: tb/irq_status_reg_tb.sv
module irq_status_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_rd = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       evt_aud_ovf = 1'b0;
  logic       evt_vid_ovf = 1'b0;
  logic       evt_aud_udf = 1'b0;
  logic       evt_vid_udf = 1'b0;
  logic       irq_n;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_stat = 8'h00;
  logic [7:0] m_mask = 8'h00;
  localparam logic [7:0] EVB = 8'b0011_0011;

  always #5 clk = ~clk;

  irq_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .evt_aud_ovf(evt_aud_ovf), .evt_vid_ovf(evt_vid_ovf),
    .evt_aud_udf(evt_aud_udf), .evt_vid_udf(evt_vid_udf), .irq_n(irq_n)
  );

  function automatic logic [7:0] ev_byte(input logic [3:0] e);
    return {2'b00, e[3], e[2], 2'b00, e[1], e[0]};
  endfunction
  function automatic logic [7:0] nxt_stat(input logic [7:0] s, input logic rd,
                                          input logic [3:0] e);
    return (rd ? 8'h00 : s) | ev_byte(e);
  endfunction
  function automatic logic exp_irq_n(input logic [7:0] s, input logic [7:0] m);
    return ((s & ~m & EVB) == 8'h00);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // at a falling edge: check state, drive one cycle, advance model
  task automatic step(input string req, input logic rd, input logic wr,
                      input logic [7:0] wd, input logic [3:0] e);
    chk({req, " rdata"}, host_rdata, m_stat);
    chk({req, " irq_n"}, {7'd0, irq_n}, {7'd0, exp_irq_n(m_stat, m_mask)});
    host_rd = rd; host_wr = wr; host_wdata = wd;
    {evt_vid_udf, evt_aud_udf, evt_vid_ovf, evt_aud_ovf} = e;
    #1;
    if (rd) chk({req, " pre-clear read"}, host_rdata, m_stat);
    @(posedge clk);
    m_stat = nxt_stat(m_stat, rd, e);
    if (wr) m_mask = wd & EVB;
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0; host_wdata = 8'h00;
    {evt_vid_udf, evt_aud_udf, evt_vid_ovf, evt_aud_ovf} = 4'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0107);
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", host_rdata, 8'h00);
    chk("R1 reset irq_n", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {irq_n, host_rdata[6:0]}, 8'h80);
    // R2 each event to its bit, R3 stickiness, R4 clear
    step("R2 aud ovf", 0, 0, 8'h00, 4'b0001);
    chk("R2 bit0", host_rdata, 8'h01);
    step("R3 repeat", 0, 0, 8'h00, 4'b0001);
    step("R2 vid ovf", 0, 0, 8'h00, 4'b0010);
    step("R2 aud udf", 0, 0, 8'h00, 4'b0100);
    step("R2 vid udf", 0, 0, 8'h00, 4'b1000);
    chk("R2 all bits", host_rdata, 8'h33);
    step("R3 hold", 0, 0, 8'h00, 4'b0000);
    step("R4 read", 1, 0, 8'h00, 4'b0000);
    chk("R4 cleared", host_rdata, 8'h00);
    chk("R7 idle", {7'd0, irq_n}, 8'h01);
    // R5 event colliding with read
    step("R5 setup", 0, 0, 8'h00, 4'b0001);
    step("R5 collide", 1, 0, 8'h00, 4'b1000);
    chk("R5 kept", host_rdata, 8'h20);
    step("R5 drain", 1, 0, 8'h00, 4'b0000);
    // R6 write leaves status, R8 masked still records
    step("R6 pre", 0, 0, 8'h00, 4'b0010);
    step("R6 write", 0, 1, 8'h02, 4'b0000);
    chk("R6 status kept", host_rdata, 8'h02);
    chk("R8 masked irq", {7'd0, irq_n}, 8'h01);
    step("R8 masked event", 0, 0, 8'h00, 4'b0010);
    chk("R8 recorded", host_rdata, 8'h02);
    step("R7 unmasked", 0, 0, 8'h00, 4'b0100);
    chk("R7 low", {7'd0, irq_n}, 8'h00);
    step("R6 mask all", 0, 1, 8'h33, 4'b0000);
    chk("R6 all masked", {7'd0, irq_n}, 8'h01);
    step("R6 unmask", 0, 1, 8'h00, 4'b0000);
    chk("R7 unmask low", {7'd0, irq_n}, 8'h00);
    step("R4 clr", 1, 0, 8'h00, 4'b0000);
    // R9 reserved bits
    step("R9 rsvd write", 0, 1, 8'hCC, 4'b0001);
    chk("R9 rsvd no mask", {7'd0, irq_n}, 8'h00);
    chk("R9 rsvd read", host_rdata & 8'hCC, 8'h00);
    step("R9 clr", 1, 1, 8'h00, 4'b0000);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] e;
      logic rd, wr;
      logic [7:0] wd;
      e  = 4'($urandom) & 4'($urandom) & 4'($urandom);
      rd = ($urandom % 5) == 0;
      wr = ($urandom % 7) == 0;
      wd = 8'($urandom);
      step("R7 random", rd, wr, wd, e);
      chk("R9 random rsvd", host_rdata & 8'hCC, 8'h00);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule